// File: doc/BRIEF.md
# Banked Attribute Register Access Controller

This block holds one 32-bit attribute register that exists as a secure copy and a non-secure copy. Coprocessor-style register requests arrive with an encoding (coprocessor number, two opcode fields, two register-number fields), a direction and write data. The block checks whether the encoding names its register and then evaluates the privilege level and the hypervisor trap controls. It decides whether the access is undefined, is trapped to the hypervisor level, or completes against one of the two copies.

The secure copy is reachable only from the highest privilege level (level 3) while the secure-state input is low. Every other completing access uses the non-secure storage, which also serves as the common copy. Two secure-disable inputs can lock out secure writes. Each accepted request gives one registered response on the next cycle. The response carries read data, an undefined flag, a trap flag, a trap code and a flag that selects the trap reporting style.

Top module: `sreg_bank_ctrl`

## Requirements
- R1: A request is accepted only when coprocessor = 15, opc1 = 0, CRn = 10, CRm = 3 and opc2 = 1. Any other encoding produces no response (rsp_valid stays 0) and changes neither copy.
- R2: Any accepted request at privilege level 0, read or write, responds with rsp_undef = 1 and rsp_trap = 0.
- R3: At level 1 with the hypervisor enabled, the checks run in this order: the per-register trap bit in its 64-bit form, then in its 32-bit form, then the virtual-memory trap bit in its 64-bit form, then in its 32-bit form. The 64-bit forms apply only when the hypervisor runs in 64-bit state, and the 32-bit forms only when it runs in 32-bit state. The first bit that is set raises rsp_trap = 1 with rsp_trap_code = 0x03.
- R4: Reads test only the read virtual-memory trap bits, and writes test only the write virtual-memory trap bits. The other direction's bits have no effect.
- R5: On a trap, rsp_trap_style is 0 (system-access trap) when the hypervisor is in 64-bit state and 1 (hypervisor trap exception) when it is in 32-bit state.
- R6: An access at level 1 or level 2 that is not trapped reads or writes the non-secure copy. Trap controls have no effect at levels 2 and 3, or when the hypervisor is disabled.
- R7: At level 3, sec_ns = 0 selects the secure copy and sec_ns = 1 selects the non-secure copy.
- R8: At level 3 with sec_ns = 0, a write responds undefined when sec_lock_a or sec_lock_b is high. Secure reads and non-secure writes ignore both locks.
- R9: After reset, both copies read as zero and all response outputs are zero.
- R10: The response appears in the cycle after the request. A write is visible to a read issued in the next cycle. A trapped or undefined access leaves both copies unchanged and returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_is64 | input | 1 | Hypervisor runs in 64-bit state |
| sec_ns | input | 1 | Non-secure state bit |
| sec_lock_a | input | 1 | First secure-write disable |
| sec_lock_b | input | 1 | Second secure-write disable |
| trap_reg64 | input | 1 | Per-register trap bit, 64-bit form |
| trap_reg32 | input | 1 | Per-register trap bit, 32-bit form |
| trap_vmrd64 | input | 1 | Read virtual-memory trap, 64-bit form |
| trap_vmrd32 | input | 1 | Read virtual-memory trap, 32-bit form |
| trap_vmwr64 | input | 1 | Write virtual-memory trap, 64-bit form |
| trap_vmwr32 | input | 1 | Write virtual-memory trap, 32-bit form |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Undefined result |
| rsp_trap | output | 1 | Trapped to hypervisor |
| rsp_trap_code | output | 6 | Trap code (0x03 on a trap) |
| rsp_trap_style | output | 1 | 0 = system-access trap, 1 = hypervisor trap exception |

## Verification
A wrong copy selection, or a write that lands when it should be blocked, corrupts hidden storage. The corruption shows at the ports only when that copy is read back, so the bench reads both copies right after every swept request. Every fault of that kind then surfaces within two cycles. Wrong trap priority, the wrong direction's control, or a missed lock shows up in the flags of the very next response.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 6;
  localparam logic [CODE_W-1:0] TRAP_CODE = 6'h03;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_KERN  = 2'd1,
    LVL_HYP   = 2'd2,
    LVL_MON   = 2'd3
  } lvl_e;

  typedef struct packed {
    logic ok;
    logic undef;
    logic trap;
    logic style;
    logic sel_sec;
  } verdict_t;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode #(
  parameter logic [3:0] CP_ID  = 4'd15,
  parameter logic [2:0] OP1_ID = 3'd0,
  parameter logic [3:0] CRN_ID = 4'd10,
  parameter logic [3:0] CRM_ID = 4'd3,
  parameter logic [2:0] OP2_ID = 3'd1
) (
  input  logic [3:0] cp,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  localparam int NF = 5;
  logic [NF-1:0] fld_eq;

  always_comb begin
    fld_eq[0] = (cp  == CP_ID);
    fld_eq[1] = (op1 == OP1_ID);
    fld_eq[2] = (crn == CRN_ID);
    fld_eq[3] = (crm == CRM_ID);
    fld_eq[4] = (op2 == OP2_ID);
    hit       = &fld_eq;
  end
endmodule

// File: rtl/sreg_policy.sv
module sreg_policy
  import sreg_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       is_write,
  input  logic       hyp_en,
  input  logic       hyp_is64,
  input  logic       sec_ns,
  input  logic       sec_lock_a,
  input  logic       sec_lock_b,
  input  logic       trap_reg64,
  input  logic       trap_reg32,
  input  logic       trap_vmrd64,
  input  logic       trap_vmrd32,
  input  logic       trap_vmwr64,
  input  logic       trap_vmwr32,
  output verdict_t   verdict
);
  lvl_e lvl;
  logic vm64, vm32;
  logic chk64, chk32;

  always_comb begin
    lvl   = lvl_e'(priv_lvl);
    vm64  = is_write ? trap_vmwr64 : trap_vmrd64;
    vm32  = is_write ? trap_vmwr32 : trap_vmrd32;
    chk64 = hyp_en &&  hyp_is64;
    chk32 = hyp_en && !hyp_is64;
    verdict         = '0;
    verdict.style   = !hyp_is64;
    unique case (lvl)
      LVL_USER: verdict.undef = 1'b1;
      LVL_KERN: begin
        if      (chk64 && trap_reg64) verdict.trap = 1'b1;
        else if (chk32 && trap_reg32) verdict.trap = 1'b1;
        else if (chk64 && vm64)       verdict.trap = 1'b1;
        else if (chk32 && vm32)       verdict.trap = 1'b1;
        else                          verdict.ok   = 1'b1;
      end
      LVL_HYP: verdict.ok = 1'b1;
      LVL_MON: begin
        if (!sec_ns && is_write && (sec_lock_a || sec_lock_b)) begin
          verdict.undef = 1'b1;
        end else begin
          verdict.ok      = 1'b1;
          verdict.sel_sec = !sec_ns;
        end
      end
      default: verdict.undef = 1'b1;
    endcase
  end

  always_comb begin
    assert_verdict_exclusive_R10: assert ($onehot0({verdict.ok, verdict.undef, verdict.trap}));
  end
endmodule

// File: rtl/sreg_store.sv
module sreg_store
  import sreg_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         sel_sec,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] copy_sec_q, copy_ns_q;
  logic [W-1:0] copy_sec_d, copy_ns_d;
  logic         en_sec, en_ns;

  always_comb begin
    en_sec     = wr_en &&  sel_sec;
    en_ns      = wr_en && !sel_sec;
    copy_sec_d = wr_data;
    copy_ns_d  = wr_data;
    rd_data    = sel_sec ? copy_sec_q : copy_ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_sec_q <= '0;
    end else if (en_sec) begin
      copy_sec_q <= copy_sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_ns_q <= '0;
    end else if (en_ns) begin
      copy_ns_q <= copy_ns_d;
    end
  end

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(copy_sec_q) && $stable(copy_ns_q)));
  assert_sec_write_spares_ns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_sec) |=> $stable(copy_ns_q));
  assert_ns_write_spares_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_sec) |=> $stable(copy_sec_q));
endmodule

// File: rtl/sreg_bank_ctrl.sv
module sreg_bank_ctrl
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_cp,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        priv_lvl,
  input  logic              hyp_en,
  input  logic              hyp_is64,
  input  logic              sec_ns,
  input  logic              sec_lock_a,
  input  logic              sec_lock_b,
  input  logic              trap_reg64,
  input  logic              trap_reg32,
  input  logic              trap_vmrd64,
  input  logic              trap_vmrd32,
  input  logic              trap_vmwr64,
  input  logic              trap_vmwr32,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [5:0]        rsp_trap_code,
  output logic              rsp_trap_style
);
  logic        hit, accept, wr_en;
  verdict_t    verdict;
  logic [DATA_W-1:0] store_rd;

  logic              valid_d, undef_d, trap_d, style_d;
  logic [DATA_W-1:0] rdata_d;
  logic [CODE_W-1:0] code_d;

  sreg_decode u_decode (
    .cp(req_cp), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .hit(hit)
  );

  sreg_policy u_policy (
    .priv_lvl(priv_lvl), .is_write(req_write), .hyp_en(hyp_en), .hyp_is64(hyp_is64),
    .sec_ns(sec_ns), .sec_lock_a(sec_lock_a), .sec_lock_b(sec_lock_b),
    .trap_reg64(trap_reg64), .trap_reg32(trap_reg32),
    .trap_vmrd64(trap_vmrd64), .trap_vmrd32(trap_vmrd32),
    .trap_vmwr64(trap_vmwr64), .trap_vmwr32(trap_vmwr32),
    .verdict(verdict)
  );

  sreg_store #(.W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_sec(verdict.sel_sec),
    .wr_data(req_wdata), .rd_data(store_rd)
  );

  always_comb begin
    accept  = req_valid && hit;
    wr_en   = accept && verdict.ok && req_write;
    valid_d = accept;
    undef_d = accept && verdict.undef;
    trap_d  = accept && verdict.trap;
    style_d = trap_d && verdict.style;
    code_d  = trap_d ? TRAP_CODE : '0;
    rdata_d = (accept && verdict.ok && !req_write) ? store_rd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_undef      <= 1'b0;
      rsp_trap       <= 1'b0;
      rsp_trap_style <= 1'b0;
      rsp_trap_code  <= '0;
      rsp_rdata      <= '0;
    end else begin
      rsp_valid      <= valid_d;
      rsp_undef      <= undef_d;
      rsp_trap       <= trap_d;
      rsp_trap_style <= style_d;
      rsp_trap_code  <= code_d;
      rsp_rdata      <= rdata_d;
    end
  end

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  assert_user_level_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && priv_lvl == 2'd0) |=> (rsp_undef && !rsp_trap));
  assert_trap_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_trap_code == 6'h03 && rsp_valid));
  assert_refused_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_trap || rsp_undef) |-> (rsp_rdata == '0));
  assert_locked_sec_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && req_write && priv_lvl == 2'd3 && !sec_ns && (sec_lock_a || sec_lock_b))
    |=> rsp_undef);
  assert_no_trap_above_kern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_lvl >= 2'd2) |=> !rsp_trap);
endmodule

// File: tb/sreg_bank_ctrl_test.sv
module sreg_bank_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [3:0] req_cp, req_crn, req_crm;
  logic [2:0] req_op1, req_op2;
  logic [31:0] req_wdata;
  logic [1:0] priv_lvl;
  logic hyp_en, hyp_is64, sec_ns, sec_lock_a, sec_lock_b;
  logic trap_reg64, trap_reg32, trap_vmrd64, trap_vmrd32, trap_vmwr64, trap_vmwr32;
  logic rsp_valid, rsp_undef, rsp_trap, rsp_trap_style;
  logic [31:0] rsp_rdata;
  logic [5:0] rsp_trap_code;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_sec, m_ns;

  always #4 clk = ~clk;

  sreg_bank_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_wdata = '0;
    req_cp = 4'd15; req_op1 = 3'd0; req_crn = 4'd10; req_crm = 4'd3; req_op2 = 3'd1;
    priv_lvl = 2'd0; hyp_en = 0; hyp_is64 = 0; sec_ns = 0; sec_lock_a = 0; sec_lock_b = 0;
    {trap_reg64, trap_reg32, trap_vmrd64, trap_vmrd32, trap_vmwr64, trap_vmwr32} = '0;
  endtask

  // level-3 read of one copy; checks read data against the model
  task automatic read_copy(input logic ns, input string tag);
    idle_inputs();
    req_valid = 1; priv_lvl = 2'd3; sec_ns = ns;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_rdata, ns ? m_ns : m_sec);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    m_sec = '0; m_ns = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid at reset", {31'd0, rsp_valid}, 32'd0);
    chk("R9 rdata at reset", rsp_rdata, 32'd0);
    chk("R9 flags at reset", {rsp_undef, rsp_trap, rsp_trap_style, rsp_trap_code}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    read_copy(1'b0, "R9 secure copy zero");
    read_copy(1'b1, "R9 non-secure copy zero");

    // R1: each field off its value, level-3 non-secure write must be ignored
    for (int f = 0; f < 5; f++) begin
      for (int v = 0; v < 16; v++) begin
        idle_inputs();
        req_valid = 1; req_write = 1; priv_lvl = 2'd3; sec_ns = 1;
        req_wdata = 32'hBAD0_0000 | (f << 8) | v;
        case (f)
          0: req_cp  = 4'(v);
          1: req_op1 = 3'(v);
          2: req_crn = 4'(v);
          3: req_crm = 4'(v);
          default: req_op2 = 3'(v);
        endcase
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        if (req_cp == 15 && req_op1 == 0 && req_crn == 10 && req_crm == 3 && req_op2 == 1) begin
          m_ns = req_wdata;
          chk("R1 matching encoding accepted", {31'd0, rsp_valid}, 32'd1);
        end else begin
          chk("R1 foreign encoding no response", {31'd0, rsp_valid}, 32'd0);
        end
        read_copy(1'b1, "R1 non-secure copy after decode sweep");
      end
    end
    read_copy(1'b0, "R1 secure copy untouched");

    // Full sweep of level, direction, hypervisor state, trap bits, state bit, locks
    for (int i = 0; i < 16384; i++) begin
      logic [1:0] lv; logic wr, he, h64, ns, la, lb;
      logic [5:0] tb;
      logic e_undef, e_trap, e_sec, vm64, vm32;
      logic [31:0] e_rd;
      lv = i[1:0]; wr = i[2]; he = i[3]; h64 = i[4]; tb = i[10:5];
      ns = i[11]; la = i[12]; lb = i[13];
      idle_inputs();
      req_valid = 1; req_write = wr; req_wdata = {i[15:0], ~i[15:0]};
      priv_lvl = lv; hyp_en = he; hyp_is64 = h64; sec_ns = ns;
      sec_lock_a = la; sec_lock_b = lb;
      {trap_reg64, trap_reg32, trap_vmrd64, trap_vmrd32, trap_vmwr64, trap_vmwr32} = tb;
      vm64 = wr ? tb[1] : tb[3];
      vm32 = wr ? tb[0] : tb[2];
      e_undef = 0; e_trap = 0; e_sec = 0;
      if (lv == 0) e_undef = 1;
      else if (lv == 1 && he) e_trap = h64 ? (tb[5] || vm64) : (tb[4] || vm32);
      else if (lv == 3 && !ns && wr && (la || lb)) e_undef = 1;
      if (lv == 3 && !ns) e_sec = 1;
      e_rd = (!e_undef && !e_trap && !wr) ? (e_sec ? m_sec : m_ns) : 32'd0;
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      if (!e_undef && !e_trap && wr) begin
        if (e_sec) m_sec = req_wdata; else m_ns = req_wdata;
      end
      chk("R10 response next cycle", {31'd0, rsp_valid}, 32'd1);
      chk("R2/R8 undefined flag", {31'd0, rsp_undef}, {31'd0, e_undef});
      chk("R3/R4/R6 trap flag", {31'd0, rsp_trap}, {31'd0, e_trap});
      if (e_trap) begin
        chk("R3 trap code", {26'd0, rsp_trap_code}, 32'h3);
        chk("R5 trap style", {31'd0, rsp_trap_style}, {31'd0, !h64});
      end
      chk("R10 read data", rsp_rdata, e_rd);
      read_copy(1'b0, "R7/R8 secure copy contents");
      read_copy(1'b1, "R6/R7 non-secure copy contents");
    end

    // write then immediate read on the next cycle
    idle_inputs();
    req_valid = 1; req_write = 1; priv_lvl = 2'd2; req_wdata = 32'h5A5A_C3C3;
    @(negedge clk);
    req_write = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R10 back-to-back read sees write", rsp_rdata, 32'h5A5A_C3C3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule